// File: doc/BRIEF.md
# Dual-Width Asynchronous Bus Master

This block runs asynchronous, strobe-handshaked bus cycles for an internal requester. One request (byte address, write data, two byte enables, direction) produces one bus cycle: the address and direction go out first, the address strobe follows, then the data strobes, and the cycle holds until an acknowledge arrives. Read data and a one-clock done pulse then go back to the requester. A static width input picks the bus width. In 16-bit mode the two shared strobe pins are the upper and lower data strobes. In 8-bit mode the first one carries address bit 0 with address timing, and the second is the single data strobe.

The acknowledge comes from two places. The first is an external pin, sampled through a two-flop synchronizer. The second is an internal chip-select window: any access whose address lies inside an inclusive range is acknowledged after a programmed wait count. This applies to the block's own cycles. It also applies to cycles run by another master while this block is not bus master, and in that case the block drives only the acknowledge pin. Bus pins are driven only during a cycle. When no cycle is running, every output enable is low.

The controller is a state machine with six states. `S_IDLE` goes to `S_ADDR` when an accepted request is valid, and to `S_ERR` when the request is not valid. `S_ADDR` always goes to `S_AS`, and `S_AS` always goes to `S_DS`. `S_DS` goes to `S_END` when an acknowledge arrives. `S_END` and `S_ERR` both return to `S_IDLE`.

Top module: `async_bus_master`

## Requirements
- R1: After reset, `as_n_o`, `lds_ds_o` and `dtack_n_o` are high, all output enables are low, and `done_o` and `err_o` are low.
- R2: A cycle has these phases in order:
  - one clock with the pins driven and `as_n_o` high;
  - one clock with `as_n_o` low and the data strobes high;
  - the strobe phase;
  - one closing clock with the strobes high and `done_o` high for exactly that clock.
  
  A cycle therefore spans at least 4 clocks of driven pins.
- R3: In 16-bit mode (`width16_i`=1) the strobe phase pulls `uds_a0_o` low when `req_be_i[1]` is set (lane 15..8) and `lds_ds_o` low when `req_be_i[0]` is set (lane 7..0). On a read, `rdata_o` holds `data_i` on the enabled lanes and zero on the others.
- R4: In 8-bit mode (`width16_i`=0), `uds_a0_o` carries `req_addr_i[0]` through every driven clock, starting in the first one. `lds_ds_o` is the only data strobe. A read returns `{8'h00, data_i[7:0]}`.
- R5: On a write, in either mode, `data_oe_o` is high for every driven clock with `rw_o` low, and `data_o` carries all 16 bits of `req_wdata_i`. This includes the upper byte in 8-bit mode.
- R6: When the cycle address lies within [`cs_lo_i`, `cs_hi_i`], the strobe phase lasts `cs_wait_i`+1 clocks. In its last clock, `dtack_n_o` is low with `dtack_oe_o` high.
- R7: Outside the window, the strobe phase holds until `dtack_n_i` is low. If `dtack_n_i` falls at a falling clock edge during the strobe phase, that phase ends 2 clocks later, after the synchronizer.
- R8: A request with `req_be_i`=00, or with `req_be_i`=11 in 8-bit mode, runs no bus cycle. It gives one clock of `done_o` together with `err_o`.
- R9: If `master_i` falls during a cycle, the cycle still completes with a single `done_o`. All output enables go low on the clock after `done_o`.
- R10: A request presented while `master_i` is low is ignored: no pins are driven and no `done_o` is given.
- R11: While not bus master and idle, if `as_n_i` is low with `{bus_addr_i,1'b0}` inside the window, the block drives `dtack_n_o` low `cs_wait_i` clocks after the strobe falls. Outside the window, `dtack_oe_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| width16_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus (static) |
| master_i | input | 1 | Block currently owns the bus |
| req_valid_i | input | 1 | Request strobe (one clock) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 2*LANE_W | Write data |
| req_be_i | input | 2 | Byte enables: [1] lane 15..8, [0] lane 7..0 |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Rejected request, with done_o |
| rdata_o | output | 2*LANE_W | Read data |
| cs_lo_i | input | ADDR_W | Window lower bound (inclusive) |
| cs_hi_i | input | ADDR_W | Window upper bound (inclusive) |
| cs_wait_i | input | WAIT_W | Internal acknowledge wait count |
| bus_addr_o | output | ADDR_W-1 | Address lines, bits ADDR_W-1..1 |
| bus_addr_i | input | ADDR_W-1 | Address lines as seen from the bus |
| bus_addr_oe_o | output | 1 | Address output enable |
| as_n_o | output | 1 | Address strobe, active low |
| as_n_i | input | 1 | Address strobe from the bus |
| rw_o | output | 1 | 1 = read, 0 = write |
| uds_a0_o | output | 1 | Upper strobe (16-bit) or address bit 0 (8-bit) |
| lds_ds_o | output | 1 | Lower strobe (16-bit) or data strobe (8-bit) |
| ctl_oe_o | output | 1 | Enable for strobes and rw |
| data_o | output | 2*LANE_W | Data out |
| data_i | input | 2*LANE_W | Data in |
| data_oe_o | output | 1 | Data output enable, all 16 bits |
| dtack_n_o | output | 1 | Acknowledge out, active low |
| dtack_n_i | input | 1 | Acknowledge in, active low |
| dtack_oe_o | output | 1 | Acknowledge output enable |

## Verification
The bench counts strobe clocks per lane and compares them with the wait count. A design with an off-by-one wait counter, or one that lets the counter run past its limit, would give strobes one clock too long or too short, or would lose the acknowledge. In 8-bit mode the bench checks address bit 0 on every driven clock, including the one before the address strobe; a design that gave this pin strobe timing would fail there. It also checks that the upper data byte is driven on 8-bit writes.

Further tests cover the following cases, each naming what a wrong design would show:
- **Synchronizer latency:** an external acknowledge that falls at a known strobe clock; a one-flop or unsynchronized path would finish early.
- **Mastership loss mid-cycle:** a design that released the bus at once would cut the cycle short or never give `done_o`.
- **Rejected byte-enable patterns:** a design that did not reject them would drive the bus.
- **Another master in the window:** a design that ignored the acknowledge would never answer, and a miscounting one would answer at the wrong clock.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_AS   = 3'd2,
        S_DS   = 3'd3,
        S_END  = 3'd4,
        S_ERR  = 3'd5
    } bm_state_t;
endpackage

// File: rtl/bm_sync2.sv
module bm_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bm_dtack_gen.sv
module bm_dtack_gen #(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              hit,
    output logic              ack
);
    logic [WAIT_W-1:0] cnt;

    // counts clocks since strobe assertion, holding at the programmed limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!run)            cnt <= '0;
        else if (cnt != wait_cfg) cnt <= cnt + 1'b1;
    end

    assign hit = (addr >= lo) && (addr <= hi);
    assign ack = run && hit && (cnt == wait_cfg);
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
    import bm_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANE_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                width16_i,
    input  logic                master_i,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [2*LANE_W-1:0] req_wdata_i,
    input  logic [1:0]          req_be_i,
    output logic                done_o,
    output logic                err_o,
    output logic [2*LANE_W-1:0] rdata_o,
    input  logic [ADDR_W-1:0]   cs_lo_i,
    input  logic [ADDR_W-1:0]   cs_hi_i,
    input  logic [WAIT_W-1:0]   cs_wait_i,
    output logic [ADDR_W-2:0]   bus_addr_o,
    input  logic [ADDR_W-2:0]   bus_addr_i,
    output logic                bus_addr_oe_o,
    output logic                as_n_o,
    input  logic                as_n_i,
    output logic                rw_o,
    output logic                uds_a0_o,
    output logic                lds_ds_o,
    output logic                ctl_oe_o,
    output logic [2*LANE_W-1:0] data_o,
    input  logic [2*LANE_W-1:0] data_i,
    output logic                data_oe_o,
    output logic                dtack_n_o,
    input  logic                dtack_n_i,
    output logic                dtack_oe_o
);
    localparam int DW = 2 * LANE_W;

    bm_state_t         state, nxt;
    logic              r_write;
    logic [ADDR_W-1:0] r_addr;
    logic [DW-1:0]     r_wdata;
    logic [1:0]        r_be;
    logic              reject, accept, ack, ext_ack_n;
    logic              own_run, ext_run, cs_run, cs_hit, cs_ack;
    logic [ADDR_W-1:0] cs_addr;
    logic [DW-1:0]     rd_masked;

    assign accept = req_valid_i && master_i;
    assign reject = (req_be_i == 2'b00) || (!width16_i && req_be_i == 2'b11);

    // acknowledge sources
    bm_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(dtack_n_i), .q(ext_ack_n)
    );

    assign own_run = (state == S_DS);
    assign ext_run = !master_i && (state == S_IDLE) && !as_n_i;
    assign cs_run  = own_run || ext_run;
    assign cs_addr = own_run ? r_addr : {bus_addr_i, 1'b0};

    bm_dtack_gen #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dtack (
        .clk(clk), .rst_n(rst_n), .run(cs_run), .addr(cs_addr),
        .lo(cs_lo_i), .hi(cs_hi_i), .wait_cfg(cs_wait_i),
        .hit(cs_hit), .ack(cs_ack)
    );

    assign ack = cs_ack || !ext_ack_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (accept) nxt = reject ? S_ERR : S_ADDR;
            S_ADDR:  nxt = S_AS;
            S_AS:    nxt = S_DS;
            S_DS:    if (ack) nxt = S_END;
            S_END:   nxt = S_IDLE;
            S_ERR:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // request capture and read data latch
    assign rd_masked = width16_i ?
        { (r_be[1] ? data_i[DW-1:LANE_W] : {LANE_W{1'b0}}),
          (r_be[0] ? data_i[LANE_W-1:0]  : {LANE_W{1'b0}}) } :
        { {LANE_W{1'b0}}, data_i[LANE_W-1:0] };

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            r_be    <= '0;
            rdata_o <= '0;
        end else begin
            if (state == S_IDLE && accept) begin
                r_write <= req_write_i;
                r_addr  <= req_addr_i;
                r_wdata <= req_wdata_i;
                r_be    <= req_be_i;
            end
            if (state == S_DS && ack && !r_write) rdata_o <= rd_masked;
        end
    end

    // outputs
    always_comb begin
        bus_addr_o    = r_addr[ADDR_W-1:1];
        data_o        = r_wdata;
        bus_addr_oe_o = 1'b0;
        ctl_oe_o      = 1'b0;
        data_oe_o     = 1'b0;
        as_n_o        = 1'b1;
        rw_o          = 1'b1;
        uds_a0_o      = 1'b1;
        lds_ds_o      = 1'b1;
        done_o        = 1'b0;
        err_o         = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_ADDR, S_AS, S_DS, S_END: begin
                bus_addr_oe_o = 1'b1;
                ctl_oe_o      = 1'b1;
                data_oe_o     = r_write;
                rw_o          = !r_write;
                if (!width16_i) uds_a0_o = r_addr[0];
                if (state == S_AS || state == S_DS) as_n_o = 1'b0;
                if (state == S_DS) begin
                    if (width16_i) begin
                        uds_a0_o = !r_be[1];
                        lds_ds_o = !r_be[0];
                    end else begin
                        lds_ds_o = 1'b0;
                    end
                end
                if (state == S_END) done_o = 1'b1;
            end
            S_ERR: begin
                done_o = 1'b1;
                err_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign dtack_oe_o = cs_run && cs_hit;
    assign dtack_n_o  = !cs_ack;
endmodule

// File: rtl/async_bus_master_chk.sv
module async_bus_master_chk (
    input logic clk,
    input logic rst_n,
    input logic width16_i,
    input logic as_n_o,
    input logic bus_addr_oe_o,
    input logic ctl_oe_o,
    input logic lds_ds_o,
    input logic uds_a0_o,
    input logic done_o,
    input logic err_o,
    input logic data_oe_o,
    input logic rw_o
);
    AST_AS_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n_o |-> bus_addr_oe_o); // R2
    AST_LDS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe_o && !lds_ds_o) |-> !as_n_o); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_UDS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe_o && width16_i && !uds_a0_o) |-> !as_n_o); // R3
    AST_A0_ADDR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe_o && $past(ctl_oe_o) && !width16_i) |-> $stable(uds_a0_o)); // R4
    AST_WRITE_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (ctl_oe_o && !rw_o)); // R5
    AST_REJECT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && !ctl_oe_o)); // R8
    AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_oe_o) |-> $past(done_o)); // R9
endmodule

bind async_bus_master async_bus_master_chk chk_i (
    .clk(clk), .rst_n(rst_n), .width16_i(width16_i), .as_n_o(as_n_o),
    .bus_addr_oe_o(bus_addr_oe_o), .ctl_oe_o(ctl_oe_o), .lds_ds_o(lds_ds_o),
    .uds_a0_o(uds_a0_o), .done_o(done_o), .err_o(err_o),
    .data_oe_o(data_oe_o), .rw_o(rw_o)
);

// File: tb/async_bus_master_tb_top.sv
`timescale 1ns/1ps
module async_bus_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        width16_i = 1'b1, master_i = 1'b1;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [23:0] req_addr_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic [1:0]  req_be_i = '0;
    logic        done_o, err_o;
    logic [15:0] rdata_o;
    logic [23:0] cs_lo_i = 24'h001000, cs_hi_i = 24'h001FFF;
    logic [3:0]  cs_wait_i = '0;
    logic [22:0] bus_addr_o, bus_addr_i = '0;
    logic        bus_addr_oe_o, as_n_o, as_n_i = 1'b1, rw_o;
    logic        uds_a0_o, lds_ds_o, ctl_oe_o;
    logic [15:0] data_o, data_i = 16'hA5C3;
    logic        data_oe_o, dtack_n_o, dtack_n_i = 1'b1, dtack_oe_o;

    int checks = 0, errors = 0;
    int m_drv, m_uds, m_lds, m_doe, m_dtk, m_done, m_err;
    bit m_order_ok, m_a0_ok, m_rel_ok;
    logic [15:0] m_rdata, m_dout;

    always #2.5 clk = ~clk;

    async_bus_master dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_cyc(input bit w, input [23:0] a, input [15:0] wd,
                           input [1:0] be, input int ext_d, input int drop_at);
        m_drv = 0; m_uds = 0; m_lds = 0; m_doe = 0; m_dtk = 0; m_done = 0; m_err = 0;
        m_order_ok = 1; m_a0_ok = 1; m_rel_ok = 1; m_rdata = '0; m_dout = '0;
        @(negedge clk);
        req_valid_i = 1; req_write_i = w; req_addr_i = a; req_wdata_i = wd; req_be_i = be;
        @(negedge clk);
        req_valid_i = 0;
        for (int i = 0; i < 60; i++) begin
            if (ctl_oe_o) begin
                m_drv++;
                if (m_drv == 1 && !as_n_o) m_order_ok = 0;
                if (m_drv == 2 && (as_n_o || !lds_ds_o)) m_order_ok = 0;
                if (!width16_i && uds_a0_o != a[0]) m_a0_ok = 0;
                if (!uds_a0_o) m_uds++;
                if (!lds_ds_o) m_lds++;
            end
            if (data_oe_o) begin m_doe++; m_dout = data_o; end
            if (dtack_oe_o && !dtack_n_o) m_dtk++;
            if (ext_d > 0 && m_lds == ext_d) dtack_n_i = 0;
            if (drop_at > 0 && m_drv == drop_at) master_i = 0;
            if (done_o) begin
                m_done++; m_err = err_o; m_rdata = rdata_o;
                if (ctl_oe_o && (!as_n_o || !lds_ds_o)) m_order_ok = 0;
                @(negedge clk);
                dtack_n_i = 1;
                if (ctl_oe_o || bus_addr_oe_o || data_oe_o || done_o) m_rel_ok = 0;
                break;
            end
            @(negedge clk);
        end
        master_i = 1;
    endtask

    task automatic t_reset();
        chk(as_n_o && lds_ds_o && dtack_n_o, "R1 strobes high", {as_n_o, lds_ds_o, dtack_n_o}, 7);
        chk(!ctl_oe_o && !bus_addr_oe_o && !data_oe_o && !dtack_oe_o, "R1 enables low",
            {ctl_oe_o, bus_addr_oe_o, data_oe_o, dtack_oe_o}, 0);
        chk(!done_o && !err_o, "R1 done/err low", {done_o, err_o}, 0);
    endtask

    task automatic t_w16_read_full();
        width16_i = 1; cs_wait_i = 2;
        run_cyc(0, 24'h001234, 16'h0, 2'b11, 0, 0);
        chk(m_order_ok, "R2 phase order", m_order_ok, 1);
        chk(m_drv == 6 && m_done == 1, "R2 driven clocks", m_drv, 6);
        chk(m_uds == 3 && m_lds == 3, "R6 strobe length wait=2", {m_uds[7:0], m_lds[7:0]}, 16'h0303);
        chk(m_dtk == 1, "R6 dtack driven", m_dtk, 1);
        chk(m_rdata == 16'hA5C3, "R3 full read", m_rdata, 16'hA5C3);
        chk(m_rel_ok, "R9 release after done", m_rel_ok, 1);
    endtask

    task automatic t_w16_read_upper();
        width16_i = 1; cs_wait_i = 0;
        run_cyc(0, 24'h001100, 16'h0, 2'b10, 0, 0);
        chk(m_drv == 4, "R2 minimum four clocks", m_drv, 4);
        chk(m_uds == 1 && m_lds == 0, "R3 upper lane only", {m_uds[7:0], m_lds[7:0]}, 16'h0100);
        chk(m_rdata == 16'hA500, "R3 lower lane zeroed", m_rdata, 16'hA500);
    endtask

    task automatic t_w16_write_lower();
        width16_i = 1; cs_wait_i = 1;
        run_cyc(1, 24'h001202, 16'h1357, 2'b01, 0, 0);
        chk(m_doe == 5 && m_dout == 16'h1357, "R5 16-bit write data", m_dout, 16'h1357);
        chk(m_uds == 0 && m_lds == 2, "R3 lower lane strobe", {m_uds[7:0], m_lds[7:0]}, 16'h0002);
    endtask

    task automatic t_w8_read_odd();
        width16_i = 0; cs_wait_i = 3;
        run_cyc(0, 24'h001005, 16'h0, 2'b01, 0, 0);
        chk(m_a0_ok, "R4 A0 on every driven clock", m_a0_ok, 1);
        chk(m_lds == 4, "R4 single strobe wait=3", m_lds, 4);
        chk(m_uds == 0, "R4 A0=1 never low", m_uds, 0);
        chk(m_rdata == 16'h00C3, "R4 byte read", m_rdata, 16'h00C3);
    endtask

    task automatic t_w8_write_even();
        width16_i = 0; cs_wait_i = 0;
        run_cyc(1, 24'h001008, 16'hBEEF, 2'b10, 0, 0);
        chk(m_a0_ok && m_uds == 4, "R4 A0=0 held from address phase", m_uds, 4);
        chk(m_doe == 4, "R5 data enable over cycle", m_doe, 4);
        chk(m_dout == 16'hBEEF, "R5 upper byte still driven", m_dout, 16'hBEEF);
    endtask

    task automatic t_ext_ack();
        width16_i = 1; cs_wait_i = 0;
        run_cyc(0, 24'h004000, 16'h0, 2'b01, 3, 0);
        chk(m_lds == 5, "R7 synchronizer latency", m_lds, 5);
        chk(m_dtk == 0, "R7 no internal ack outside window", m_dtk, 0);
        chk(m_rdata == 16'h00C3, "R7 read data", m_rdata, 16'h00C3);
    endtask

    task automatic t_reject();
        width16_i = 0;
        run_cyc(0, 24'h001000, 16'h0, 2'b11, 0, 0);
        chk(m_drv == 0 && m_done == 1 && m_err == 1, "R8 8-bit wide request",
            {m_drv[3:0], m_done[3:0], m_err[3:0]}, 12'h011);
        width16_i = 1;
        run_cyc(1, 24'h001000, 16'h0, 2'b00, 0, 0);
        chk(m_drv == 0 && m_done == 1 && m_err == 1, "R8 empty byte enables",
            {m_drv[3:0], m_done[3:0], m_err[3:0]}, 12'h011);
    endtask

    task automatic t_drop();
        width16_i = 1; cs_wait_i = 4;
        run_cyc(0, 24'h001400, 16'h0, 2'b11, 0, 2);
        chk(m_done == 1 && m_drv == 8, "R9 cycle completes after drop", m_drv, 8);
        chk(m_rel_ok, "R9 released after done", m_rel_ok, 1);
        chk(m_rdata == 16'hA5C3, "R9 read data kept", m_rdata, 16'hA5C3);
    endtask

    task automatic t_not_master();
        bit seen = 0;
        master_i = 0;
        @(negedge clk);
        req_valid_i = 1; req_be_i = 2'b11; req_addr_i = 24'h001000;
        @(negedge clk);
        req_valid_i = 0;
        for (int i = 0; i < 8; i++) begin
            if (ctl_oe_o || bus_addr_oe_o || done_o) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R10 request ignored when not master", seen, 0);
        master_i = 1;
    endtask

    task automatic t_ext_master();
        master_i = 0; cs_wait_i = 3;
        @(negedge clk);
        bus_addr_i = 23'h000900; as_n_i = 0;
        @(negedge clk);
        @(negedge clk);
        chk(dtack_oe_o && dtack_n_o, "R11 not yet acked at 2", {dtack_oe_o, dtack_n_o}, 3);
        @(negedge clk);
        chk(dtack_oe_o && !dtack_n_o, "R11 acked at wait=3", {dtack_oe_o, dtack_n_o}, 2);
        as_n_i = 1;
        @(negedge clk);
        bus_addr_i = 23'h004000; as_n_i = 0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk(!dtack_oe_o, "R11 outside window not driven", dtack_oe_o, 0);
        as_n_i = 1; master_i = 1;
        @(negedge clk);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_w16_read_full();
        t_w16_read_upper();
        t_w16_write_lower();
        t_w8_read_odd();
        t_w8_write_even();
        t_ext_ack();
        t_reject();
        t_drop();
        t_not_master();
        t_ext_master();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule